// File: doc/BRIEF.md
# Program Fetch Decode Router

This block sits between a processor's instruction fetch port and two program stores: an on-chip ROM of up to 16 KB and an external memory bus. A 3-bit size code sets how much of the low program space the on-chip ROM serves. On each fetch the block compares the 16-bit address with the limit that code selects. It then either asserts a ROM read for one cycle or runs a short external cycle. That cycle latches the low address byte from a shared address/data port, drives the high address byte on a separate port, and samples the returned byte from the shared port under a read strobe.

The size code lives in a register that software can read at any time. Writes to it are protected. Software must first write a two-byte key to a timed-access register on consecutive cycles, and the protected write must land in a short window after that. A new code governs the very next fetch, so code that changes the boundary should run from a region that keeps its place on both sides of the change.

Top module: `prog_decode_router`

## Requirements
- R1: During and after a synchronous reset, the size code is 5 (reads return 05h), and `rom_en`, `ext_ale`, `ext_psen` and `ext_data_valid` are low.
- R2: The size code selects the internal limit: code 1 gives 1024 bytes, 2 gives 2048, 3 gives 4096, 4 gives 8192 and 5 gives 16384. An accepted fetch whose address is below the limit is served internally, and all other accepted fetches go to the external bus.
- R3: With code 0, every address from 0000h to FFFFh is fetched externally.
- R4: An internal fetch raises `rom_en` for exactly one cycle, in the cycle after the fetch is accepted, with `rom_addr` equal to the low 14 address bits. The external strobes stay low.
- R5: An external fetch runs three cycles after acceptance. First `ext_ale` is high with `ext_ad_out` = address[7:0], `ext_ad_oe` = 1 and `ext_hi_addr` = address[15:8]. Next `ext_psen` is high with `ext_ad_oe` = 0. Last `ext_data_valid` is high and `ext_data` holds the `ext_ad_in` value sampled during the read cycle. `fetch_ready` is low during the first two cycles.
- R6: A fetch presented in the cycle right after an accepted size write is decoded with the new code.
- R7: A size write (`reg_sel` = 1) made without a valid unlock leaves the code unchanged.
- R8: The unlock is a write of AAh with `reg_sel` = 0, followed on the next cycle by a write of 55h with `reg_sel` = 0. A size write in any of the 4 cycles after the 55h write is accepted. A size write in the 5th cycle is ignored. An accepted write closes the window.
- R9: Breaking the key sequence leaves the block locked. A cycle gap between AAh and 55h, or a different byte in the second write, each count as breaking it.
- R10: A protected size write that carries code 6 or 7 is ignored and the previous code is kept.
- R11: `reg_rdata` always equals the current code in bits [2:0] with zeros in bits [7:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = timed-access key register, 1 = size register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current size code, zero-extended |
| fetch_valid | input | 1 | Fetch request, taken when `fetch_ready` is high |
| fetch_addr | input | 16 | Program address of the fetch |
| fetch_ready | output | 1 | No external fetch in progress |
| rom_en | output | 1 | Internal ROM read strobe |
| rom_addr | output | 14 | Internal ROM address |
| ext_ale | output | 1 | External address-latch strobe |
| ext_psen | output | 1 | External program-read strobe |
| ext_ad_out | output | 8 | Low address driven on the shared port |
| ext_ad_oe | output | 1 | Output enable for the shared port |
| ext_ad_in | input | 8 | Byte read back from the shared port |
| ext_hi_addr | output | 8 | High address byte |
| ext_data | output | 8 | Byte returned by an external fetch |
| ext_data_valid | output | 1 | `ext_data` holds a fresh byte |

## Verification
If the size register holds a wrong code, the fault shows on the first fetch near a boundary, one cycle later, because the fetch goes out on the wrong strobe. The sweep walks every legal code across the whole address space, including each limit and the byte just below it, so a bad limit or a bad comparison is seen within a few fetches. If the unlock state is wrong, the code changes when it should not, or fails to change when it should. Every such case is read back through `reg_rdata` in the cycle after the write, with the window probed at its last open cycle and at its first closed cycle.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam int CODE_W   = 3;
  localparam logic [CODE_W-1:0] CODE_MAX = 3'd5;
  localparam logic [CODE_W-1:0] CODE_RST = 3'd5;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_ALE  = 2'd1,
    XF_READ = 2'd2
  } xf_state_t;
endpackage

// File: rtl/pdr_ta_unlock.sv
module pdr_ta_unlock #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              consume,
  output logic              open
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic             armed;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      left  <= '0;
    end else begin
      armed <= key_wr && (key_data == KEY_FIRST);
      if (key_wr && armed && (key_data == KEY_SECOND))
        left <= CNT_W'(WINDOW);
      else if (key_wr || consume)
        left <= '0;
      else if (left != '0)
        left <= left - 1'b1;
    end
  end

  assign open = (left != '0);
endmodule

// File: rtl/pdr_size_reg.sv
module pdr_size_reg
  import pdr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int UNIT   = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              open,
  input  logic [CODE_W-1:0] wcode,
  output logic [CODE_W-1:0] code,
  output logic [ADDR_W:0]   limit,
  output logic              taken
);
  localparam int LIM_W = ADDR_W + 1;

  assign taken = wr && open;

  always_ff @(posedge clk) begin
    if (rst)
      code <= CODE_RST;
    else if (taken && (wcode <= CODE_MAX))
      code <= wcode;
  end

  always_comb begin
    if (code == '0 || code > CODE_MAX)
      limit = '0;
    else
      limit = LIM_W'(UNIT) << (code - 1'b1);
  end
endmodule

// File: rtl/pdr_ext_fetch.sv
module pdr_ext_fetch
  import pdr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        ad_in,
  output logic              ale,
  output logic              psen,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-9:0] hi_addr,
  output logic [7:0]        data,
  output logic              data_valid,
  output logic              idle
);
  xf_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= XF_IDLE;
      ale        <= 1'b0;
      psen       <= 1'b0;
      ad_out     <= '0;
      ad_oe      <= 1'b0;
      hi_addr    <= '0;
      data       <= '0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      case (state)
        XF_IDLE: if (start) begin
          state   <= XF_ALE;
          ale     <= 1'b1;
          ad_out  <= addr[7:0];
          ad_oe   <= 1'b1;
          hi_addr <= addr[ADDR_W-1:8];
        end
        XF_ALE: begin
          state <= XF_READ;
          ale   <= 1'b0;
          ad_oe <= 1'b0;
          psen  <= 1'b1;
        end
        XF_READ: begin
          state      <= XF_IDLE;
          psen       <= 1'b0;
          data       <= ad_in;
          data_valid <= 1'b1;
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assign idle = (state == XF_IDLE);
endmodule

// File: rtl/prog_decode_router.sv
module prog_decode_router
  import pdr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ROM_AW   = 14,
  parameter int UNIT     = 1024,
  parameter int TA_WIN   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              rom_en,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ext_ale,
  output logic              ext_psen,
  output logic [7:0]        ext_ad_out,
  output logic              ext_ad_oe,
  input  logic [7:0]        ext_ad_in,
  output logic [ADDR_W-9:0] ext_hi_addr,
  output logic [7:0]        ext_data,
  output logic              ext_data_valid
);
  logic              ta_open;
  logic              size_taken;
  logic [CODE_W-1:0] size_code;
  logic [ADDR_W:0]   size_limit;
  logic              xf_idle;
  logic              accept;
  logic              below;

  pdr_ta_unlock #(
    .DATA_W(8), .KEY_FIRST(8'hAA), .KEY_SECOND(8'h55), .WINDOW(TA_WIN)
  ) u_unlock (
    .clk(clk), .rst(rst),
    .key_wr(reg_wr && !reg_sel), .key_data(reg_wdata),
    .consume(size_taken), .open(ta_open)
  );

  pdr_size_reg #(.ADDR_W(ADDR_W), .UNIT(UNIT)) u_size (
    .clk(clk), .rst(rst),
    .wr(reg_wr && reg_sel), .open(ta_open),
    .wcode(reg_wdata[CODE_W-1:0]),
    .code(size_code), .limit(size_limit), .taken(size_taken)
  );

  assign accept = fetch_valid && xf_idle;
  assign below  = ({1'b0, fetch_addr} < size_limit);

  pdr_ext_fetch #(.ADDR_W(ADDR_W)) u_ext (
    .clk(clk), .rst(rst),
    .start(accept && !below), .addr(fetch_addr), .ad_in(ext_ad_in),
    .ale(ext_ale), .psen(ext_psen), .ad_out(ext_ad_out), .ad_oe(ext_ad_oe),
    .hi_addr(ext_hi_addr), .data(ext_data), .data_valid(ext_data_valid),
    .idle(xf_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_en   <= 1'b0;
      rom_addr <= '0;
    end else begin
      rom_en <= accept && below;
      if (accept && below)
        rom_addr <= fetch_addr[ROM_AW-1:0];
    end
  end

  assign fetch_ready = xf_idle;
  assign reg_rdata   = {{(8-CODE_W){1'b0}}, size_code};
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [7:0] reg_rdata,
  input logic       ta_open,
  input logic       rom_en,
  input logic       ext_ale,
  input logic       ext_psen,
  input logic       ext_ad_oe,
  input logic       ext_data_valid
);
  // R1
  reset_code_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_rdata == 8'h05 && !rom_en && !ext_ale));
  // R4
  path_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rom_en && (ext_ale || ext_psen)));
  // R5
  ale_then_psen_chk: assert property (@(posedge clk) disable iff (rst)
    ext_ale |=> (ext_psen && !ext_ad_oe && !ext_ale));
  // R5
  psen_then_data_chk: assert property (@(posedge clk) disable iff (rst)
    ext_psen |=> (ext_data_valid && !ext_psen));
  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && !ta_open) |=> $stable(reg_rdata));
  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata <= 8'h05);
endmodule

bind prog_decode_router pdr_checker u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_rdata(reg_rdata), .ta_open(ta_open), .rom_en(rom_en),
  .ext_ale(ext_ale), .ext_psen(ext_psen), .ext_ad_oe(ext_ad_oe),
  .ext_data_valid(ext_data_valid)
);

// File: tb/prog_decode_router_bench.sv
`timescale 1ns/1ps
module prog_decode_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_ready, rom_en, ext_ale, ext_psen, ext_ad_oe, ext_data_valid;
  logic [13:0] rom_addr;
  logic [7:0]  ext_ad_out, ext_hi_addr, ext_data;
  logic [7:0]  ext_ad_in = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prog_decode_router u_prog_decode_router (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .rom_en(rom_en), .rom_addr(rom_addr), .ext_ale(ext_ale), .ext_psen(ext_psen),
    .ext_ad_out(ext_ad_out), .ext_ad_oe(ext_ad_oe), .ext_ad_in(ext_ad_in),
    .ext_hi_addr(ext_hi_addr), .ext_data(ext_data), .ext_data_valid(ext_data_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int code);
    return (code == 0) ? 0 : 1024 * (1 << (code - 1));
  endfunction

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // AAh, 55h on consecutive cycles, gap idle cycles, then the size write
  task automatic prot_wr(input int gap, input logic [7:0] code);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hAA;
    @(negedge clk);
    reg_wdata = 8'h55;
    @(negedge clk);
    reg_wr = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = code;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] a, input bit exp_int, input string req);
    logic [7:0] rb;
    rb = a[7:0] ^ a[15:8] ^ 8'h5A;
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    if (exp_int) begin
      chk(rom_en && rom_addr == a[13:0] && !ext_ale && !ext_psen, req,
          {rom_en, ext_ale, 2'b0, rom_addr}, {1'b1, 1'b0, 2'b0, a[13:0]});
      @(negedge clk);
      chk(!rom_en, {req, " rom_en one cycle"}, rom_en, 0);
    end else begin
      chk(ext_ale && !rom_en && ext_ad_oe && ext_ad_out == a[7:0] && ext_hi_addr == a[15:8]
          && !fetch_ready, {req, " R5 ale"},
          {rom_en, ext_ale, ext_ad_oe, ext_hi_addr, ext_ad_out}, {3'b011, a});
      ext_ad_in = rb;
      @(negedge clk);
      chk(ext_psen && !ext_ale && !ext_ad_oe, {req, " R5 psen"},
          {ext_psen, ext_ale, ext_ad_oe}, 3'b100);
      @(negedge clk);
      chk(ext_data_valid && ext_data == rb && fetch_ready, {req, " R5 data"},
          {ext_data_valid, ext_data}, {1'b1, rb});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is still high, then after release
    chk(reg_rdata == 8'h05 && !rom_en && !ext_ale && !ext_psen && !ext_data_valid,
        "R1 in reset", reg_rdata, 5);
    rst = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h05 && !rom_en && !ext_ale && !ext_psen && !ext_data_valid,
        "R1 after reset", reg_rdata, 5);
    // R11: read gives zero-extended code
    chk(reg_rdata[7:3] == 5'b0, "R11 upper bits", reg_rdata, 5);
    // R7: size write without unlock
    wr(1'b1, 8'h03);
    chk(reg_rdata == 8'h05, "R7 locked write", reg_rdata, 5);
    // R9: gap between keys
    wr(1'b0, 8'hAA); wr(1'b0, 8'h55); wr(1'b1, 8'h02);
    chk(reg_rdata == 8'h05, "R9 gap between keys", reg_rdata, 5);
    // R9: wrong second key
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hAA;
    @(negedge clk); reg_wdata = 8'h56;
    @(negedge clk); reg_sel = 1'b1; reg_wdata = 8'h02;
    @(negedge clk); reg_wr = 1'b0;
    chk(reg_rdata == 8'h05, "R9 wrong second key", reg_rdata, 5);
    // R8: last open cycle accepted, first closed cycle rejected
    prot_wr(3, 8'h04);
    chk(reg_rdata == 8'h04, "R8 window cycle 4", reg_rdata, 4);
    prot_wr(4, 8'h02);
    chk(reg_rdata == 8'h04, "R8 window cycle 5", reg_rdata, 4);
    // R8: window closes after an accepted write
    prot_wr(0, 8'h01);
    chk(reg_rdata == 8'h01, "R8 immediate write", reg_rdata, 1);
    wr(1'b1, 8'h03);
    chk(reg_rdata == 8'h01, "R8 window closed after write", reg_rdata, 1);
    // R10: reserved codes
    prot_wr(1, 8'h06);
    chk(reg_rdata == 8'h01, "R10 code 6", reg_rdata, 1);
    prot_wr(2, 8'h07);
    chk(reg_rdata == 8'h01, "R10 code 7", reg_rdata, 1);
    // R6: code 5 to 3, then fetch at 1000h right after the write
    prot_wr(0, 8'h05);
    fetch(16'h1000, 1'b1, "R6 before change");
    prot_wr(0, 8'h03);
    fetch(16'h1000, 1'b0, "R6 next fetch after change");
    // R2 R3 R4 R5: sweep every legal code across the address space
    for (int c = 0; c <= 5; c++) begin
      int lim;
      prot_wr(c % 4, 8'(c));
      chk(reg_rdata == 8'(c), "R11 readback", reg_rdata, c);
      lim = lim_of(c);
      for (int a = 0; a < 65536; a += 512)
        fetch(16'(a), a < lim, (c == 0) ? "R3 sweep" : "R2 R4 sweep");
      if (lim > 0) begin
        fetch(16'(lim - 1), 1'b1, "R2 below limit");
        fetch(16'(lim), 1'b0, "R2 at limit");
      end
      fetch(16'hFFFF, 1'b0, (c == 0) ? "R3 top" : "R2 top");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule